// File: doc/BRIEF.md
# I2C Slave Bus-Condition Framer

This block is the bus-facing front end of a serial-memory slave on a two-wire I2C bus. A fast system clock oversamples the bus clock and data lines. The block finds START and STOP conditions, frames the incoming bits into bytes, and pulls the data line low to acknowledge. It reports three events to a downstream memory controller: a completed byte, the end of a read because the master did not acknowledge, and the request to commit a write. The controller raises `busy_i` while its internal programming cycle runs. During that time the framer ignores the bus completely.

The first byte after a START is the address byte. Its least significant bit selects the direction: 0 means write and 1 means read. Address matching, the memory array and shifting out read data are handled elsewhere. The parameter `MID_BYTE_HONOUR` sets what happens to a START or STOP that appears partway through a byte. With the value 0 such a condition is discarded. With the value 1 it takes effect at once.

The controller has five states, `FR_IDLE`, `FR_ADDR`, `FR_WRITE`, `FR_READ` and `FR_RDEND`, with these transitions:
- From any state, `busy_i` leads to `FR_IDLE`.
- From any state, an accepted START leads to `FR_ADDR`.
- From any state, an accepted STOP leads to `FR_IDLE`.
- `FR_ADDR` moves to `FR_WRITE` or `FR_READ` on the SCL fall that ends the address acknowledge slot. The direction bit picks which.
- `FR_READ` moves to `FR_RDEND` when the master leaves SDA high in the acknowledge slot.

Top module: `i2c_slave_framer`

## Requirements
- R1: After reset all event outputs are low and `sda_pull_low_o` is low (data line released).
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Before a START is accepted, no bit is framed, no acknowledge is driven and no event is raised.
- R3: While `busy_i` is high the block returns to idle. It ignores START, STOP and data, drives no acknowledge and raises no event.
- R4: Data bits are taken on rising SCL, most significant bit first. After the eighth bit of an address or write byte, `byte_valid_o` pulses for one cycle with `byte_data_o`. `byte_is_addr_o` is 1 only for the first byte after a START.
- R5: For the address byte and every write byte, `sda_pull_low_o` rises at the SCL fall that follows the eighth bit. It drops at the SCL fall that follows the ninth bit. It is never asserted for bytes of a read.
- R6: An address byte with bit 0 = 1 starts a read. Read bytes raise no `byte_valid_o`. SDA high sampled on the ninth rising SCL pulses `read_nak_o`. A later STOP returns the block to standby, where bytes without a new START are ignored.
- R7: A STOP after a write that carried at least one data byte pulses `commit_o` for one cycle. A STOP after a read, or after an address byte alone, does not pulse it.
- R8: A START with no STOP before it restarts framing, so the next byte is an address byte. It raises no `commit_o`, and data bytes already received are dropped for commit purposes.
- R9: With `MID_BYTE_HONOUR` = 0, a START or STOP that occurs while SCL is high, after bit 2 through bit 8 of a byte has been taken, is ignored and framing continues.
- R10: With `MID_BYTE_HONOUR` = 1, such a START or STOP is acted on immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| busy_i | input | 1 | Internal programming cycle in progress |
| sda_pull_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| byte_valid_o | output | 1 | One-cycle pulse: a byte has been received |
| byte_data_o | output | DATA_W | Received byte, valid with `byte_valid_o` |
| byte_is_addr_o | output | 1 | The reported byte is the address byte |
| read_nak_o | output | 1 | One-cycle pulse: master ended a read with no acknowledge |
| commit_o | output | 1 | One-cycle pulse: start the internal write cycle |

## Verification
The hardest situation to reach is a START or STOP placed inside a byte. The condition has to fall on an SCL high phase that is also counted as a data bit. Framing must then either carry on or restart, depending on the parameter. The bench places one instance per mode on its own view of a shared master. It times a START right after the fifth bit and a STOP right after the fourth bit. Afterwards it follows the diverging byte boundaries of the two instances through the bytes that follow. An exhaustive write of all 256 byte values covers capture and acknowledge timing.

// File: rtl/i2c_fr_pkg.sv
package i2c_fr_pkg;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_ADDR,
        FR_WRITE,
        FR_READ,
        FR_RDEND
    } fr_state_e;

endpackage

// File: rtl/i2c_fr_sync.sv
// Synchronises one bus line and flags its edges.
module i2c_fr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] pipe;
    logic              prev;

    // Idle bus level is high, so reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '1;
            prev <= 1'b1;
        end else begin
            pipe <= {pipe[STAGES-2:0], d_i};
            prev <= pipe[STAGES-1];
        end
    end

    assign lvl_o  = pipe[STAGES-1];
    assign rise_o = lvl_o & ~prev;
    assign fall_o = ~lvl_o & prev;

endmodule

// File: rtl/i2c_fr_cond.sv
// Bus condition detector with mid-byte filtering.
module i2c_fr_cond #(
    parameter bit MID_BYTE_HONOUR = 1'b0
) (
    input  logic scl_lvl_i,
    input  logic scl_rise_i,
    input  logic sda_rise_i,
    input  logic sda_fall_i,
    input  logic mid_byte_i,
    output logic start_o,
    output logic stop_o
);

    logic scl_steady_high;
    logic allow;

    assign scl_steady_high = scl_lvl_i & ~scl_rise_i;

    generate
        if (MID_BYTE_HONOUR) begin : g_honour
            assign allow = 1'b1;
        end else begin : g_filter
            assign allow = ~mid_byte_i;
        end
    endgenerate

    assign start_o = scl_steady_high & sda_fall_i & allow;
    assign stop_o  = scl_steady_high & sda_rise_i & allow;

endmodule

// File: rtl/i2c_fr_fsm.sv
// Framing controller: bit counting, acknowledge and event pulses.
module i2c_fr_fsm
    import i2c_fr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_lvl_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              mid_byte_o,
    output logic              drive_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              is_addr_o,
    output logic              nak_o,
    output logic              commit_o
);

    localparam int SLOT  = DATA_W + 1;
    localparam int CNT_W = $clog2(SLOT + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] PENULT   = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(SLOT);
    localparam logic [CNT_W-1:0] MID_LO   = CNT_W'(2);

    fr_state_e         state, nxt;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] shreg;
    logic              have_data;
    logic              framing;

    assign mid_byte_o = (bitcnt >= MID_LO) && (bitcnt <= LAST_BIT);
    assign framing    = (state == FR_ADDR) || (state == FR_WRITE) || (state == FR_READ);

    // Next-state logic
    always_comb begin
        nxt = state;
        if (busy_i) begin
            nxt = FR_IDLE;
        end else if (start_i) begin
            nxt = FR_ADDR;
        end else if (stop_i) begin
            nxt = FR_IDLE;
        end else begin
            unique case (state)
                FR_IDLE:  nxt = FR_IDLE;
                FR_ADDR:  if (scl_fall_i && bitcnt == ACK_BIT)
                              nxt = shreg[0] ? FR_READ : FR_WRITE;
                FR_WRITE: nxt = FR_WRITE;
                FR_READ:  if (scl_rise_i && bitcnt == LAST_BIT && sda_lvl_i)
                              nxt = FR_RDEND;
                FR_RDEND: nxt = FR_RDEND;
                default:  nxt = FR_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_IDLE;
        else        state <= nxt;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            shreg     <= '0;
            have_data <= 1'b0;
            drive_o   <= 1'b0;
            valid_o   <= 1'b0;
            data_o    <= '0;
            is_addr_o <= 1'b0;
            nak_o     <= 1'b0;
            commit_o  <= 1'b0;
        end else begin
            valid_o  <= 1'b0;
            nak_o    <= 1'b0;
            commit_o <= 1'b0;
            if (busy_i || start_i) begin
                bitcnt    <= '0;
                drive_o   <= 1'b0;
                have_data <= 1'b0;
            end else if (stop_i) begin
                commit_o  <= (state == FR_WRITE) && have_data;
                bitcnt    <= '0;
                drive_o   <= 1'b0;
                have_data <= 1'b0;
            end else if (framing) begin
                if (scl_rise_i) begin
                    if (bitcnt < LAST_BIT) begin
                        shreg  <= {shreg[DATA_W-2:0], sda_lvl_i};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == PENULT && state != FR_READ) begin
                            valid_o   <= 1'b1;
                            data_o    <= {shreg[DATA_W-2:0], sda_lvl_i};
                            is_addr_o <= (state == FR_ADDR);
                            if (state == FR_WRITE) have_data <= 1'b1;
                        end
                    end else if (bitcnt == LAST_BIT) begin
                        bitcnt <= ACK_BIT;
                        if (state == FR_READ && sda_lvl_i) nak_o <= 1'b1;
                    end
                end else if (scl_fall_i) begin
                    if (bitcnt == LAST_BIT && state != FR_READ) begin
                        drive_o <= 1'b1;
                    end else if (bitcnt == ACK_BIT) begin
                        drive_o <= 1'b0;
                        bitcnt  <= '0;
                    end
                end
            end
        end
    end

    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r7_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    a_r3_busy_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !(valid_o || commit_o || nak_o || drive_o));

    a_r6_nak_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
        nak_o |-> state == FR_RDEND);

    a_r5_no_ack_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> (state == FR_ADDR || state == FR_WRITE));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        state == FR_IDLE |-> !(drive_o || valid_o || nak_o));

    a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= ACK_BIT);

endmodule

// File: rtl/i2c_slave_framer.sv
module i2c_slave_framer #(
    parameter bit MID_BYTE_HONOUR = 1'b0,
    parameter int SYNC_STAGES     = 2,
    parameter int DATA_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              busy_i,
    output logic              sda_pull_low_o,
    output logic              byte_valid_o,
    output logic [DATA_W-1:0] byte_data_o,
    output logic              byte_is_addr_o,
    output logic              read_nak_o,
    output logic              commit_o
);

    localparam int N_LINES = 2;
    localparam int L_SCL   = 0;
    localparam int L_SDA   = 1;

    logic [N_LINES-1:0] raw, lvl, rise, fall;
    logic mid_byte, start_ok, stop_ok;

    assign raw[L_SCL] = scl_i;
    assign raw[L_SDA] = sda_i;

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_line
            i2c_fr_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .d_i    (raw[g]),
                .lvl_o  (lvl[g]),
                .rise_o (rise[g]),
                .fall_o (fall[g])
            );
        end
    endgenerate

    i2c_fr_cond #(.MID_BYTE_HONOUR(MID_BYTE_HONOUR)) u_cond (
        .scl_lvl_i  (lvl[L_SCL]),
        .scl_rise_i (rise[L_SCL]),
        .sda_rise_i (rise[L_SDA]),
        .sda_fall_i (fall[L_SDA]),
        .mid_byte_i (mid_byte),
        .start_o    (start_ok),
        .stop_o     (stop_ok)
    );

    i2c_fr_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_i),
        .scl_rise_i (rise[L_SCL]),
        .scl_fall_i (fall[L_SCL]),
        .sda_lvl_i  (lvl[L_SDA]),
        .start_i    (start_ok),
        .stop_i     (stop_ok),
        .mid_byte_o (mid_byte),
        .drive_o    (sda_pull_low_o),
        .valid_o    (byte_valid_o),
        .data_o     (byte_data_o),
        .is_addr_o  (byte_is_addr_o),
        .nak_o      (read_nak_o),
        .commit_o   (commit_o)
    );

endmodule

// File: tb/i2c_slave_framer_tb_top.sv
`timescale 1ns/1ps
module i2c_slave_framer_tb_top;

    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;

    logic       drv0, val0, addr0, nak0, com0;
    logic       drv1, val1, addr1, nak1, com1;
    logic [7:0] dat0, dat1;
    logic       sda0, sda1;

    int n_chk = 0;
    int n_bad = 0;
    int cv0 = 0, cv1 = 0, cc0 = 0, cc1 = 0, cn0 = 0, cn1 = 0;
    int ld0 = 0, ld1 = 0, la0 = 0, la1 = 0;

    always #2.5 clk = ~clk;

    assign sda0 = sda_m & ~drv0;
    assign sda1 = sda_m & ~drv1;

    i2c_slave_framer #(.MID_BYTE_HONOUR(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda0), .busy_i(busy),
        .sda_pull_low_o(drv0), .byte_valid_o(val0), .byte_data_o(dat0),
        .byte_is_addr_o(addr0), .read_nak_o(nak0), .commit_o(com0));

    i2c_slave_framer #(.MID_BYTE_HONOUR(1'b1)) dut_h (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda1), .busy_i(busy),
        .sda_pull_low_o(drv1), .byte_valid_o(val1), .byte_data_o(dat1),
        .byte_is_addr_o(addr1), .read_nak_o(nak1), .commit_o(com1));

    always @(negedge clk) begin
        if (val0) begin cv0++; ld0 = int'(dat0); la0 = int'(addr0); end
        if (val1) begin cv1++; ld1 = int'(dat1); la1 = int'(addr1); end
        if (com0) cc0++;
        if (com1) cc1++;
        if (nak0) cn0++;
        if (nak1) cn1++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        scl_m = 1'b0; wq();
        sda_m = b;    wq();
        scl_m = 1'b1; wq(); wq();
    endtask

    // Ninth clock: master drives v, returns slave pull-downs seen mid-high.
    task automatic ninth(input logic v, output logic a0, output logic a1);
        scl_m = 1'b0; wq();
        sda_m = v;    wq();
        scl_m = 1'b1; wq();
        a0 = drv0; a1 = drv1;
        wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic v9,
                             output logic a0, output logic a1);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        ninth(v9, a0, a1);
    endtask

    task automatic start_c();
        scl_m = 1'b0; wq();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
    endtask

    task automatic stop_c();
        scl_m = 1'b0; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(); wq();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic a0, a1;
        int b0, c0, c1, n0;

        do_reset();
        // R1 reset state
        chk("R1 pull-low", int'(drv0 | drv1), 0);
        chk("R1 events", int'(val0 | val1 | nak0 | nak1 | com0 | com1), 0);

        // R2: a byte without START is ignored
        send_byte(8'hA0, 1'b1, a0, a1);
        chk("R2 no ack", int'(a0 | a1), 0);
        chk("R2 no byte", cv0 + cv1, 0);
        stop_c();

        // R4/R5/R7: exhaustive write sweep
        start_c();
        send_byte(8'hA0, 1'b1, a0, a1);
        chk("R5 addr ack", int'(a0 & a1), 1);
        chk("R4 addr data", ld0, 'hA0);
        chk("R4 addr flag", la0, 1);
        for (int v = 0; v < 256; v++) begin
            b0 = cv0;
            send_byte(8'(v), 1'b1, a0, a1);
            chk("R4 count", cv0 - b0, 1);
            chk("R4 data", ld0, v);
            chk("R4 data h", ld1, v);
            chk("R4 flag", la0, 0);
            chk("R5 write ack", int'(a0 & a1), 1);
        end
        chk("R5 released", int'(drv0 | drv1), 1);
        stop_c();
        chk("R5 released after", int'(drv0 | drv1), 0);
        chk("R7 commit", cc0, 1);
        chk("R7 commit h", cc1, 1);

        // R7: address only, no commit
        start_c();
        send_byte(8'hA0, 1'b1, a0, a1);
        stop_c();
        chk("R7 addr only", cc0 + cc1, 2);

        // R6: read with two ACKs then NAK
        start_c();
        send_byte(8'hA1, 1'b1, a0, a1);
        chk("R6 addr ack", int'(a0 & a1), 1);
        b0 = cv0;
        send_byte(8'hFF, 1'b0, a0, a1);
        chk("R5 no read ack", int'(a0 | a1), 0);
        send_byte(8'hFF, 1'b0, a0, a1);
        chk("R6 no nak yet", cn0, 0);
        send_byte(8'hFF, 1'b1, a0, a1);
        chk("R6 nak", cn0, 1);
        chk("R6 nak h", cn1, 1);
        chk("R6 no read bytes", cv0 - b0, 0);
        stop_c();
        chk("R7 read no commit", cc0, 1);
        b0 = cv0;
        send_byte(8'h5A, 1'b1, a0, a1);
        chk("R6 standby", cv0 - b0, 0);
        chk("R6 standby ack", int'(a0 | a1), 0);
        stop_c();

        // R8: repeated START
        start_c();
        send_byte(8'hA0, 1'b1, a0, a1);
        send_byte(8'h3C, 1'b1, a0, a1);
        chk("R8 data", ld0, 'h3C);
        start_c();
        send_byte(8'hA0, 1'b1, a0, a1);
        chk("R8 addr flag", la0, 1);
        chk("R8 addr flag h", la1, 1);
        chk("R8 ack", int'(a0 & a1), 1);
        stop_c();
        chk("R8 no commit", cc0, 1);
        chk("R8 no commit h", cc1, 1);

        // R3: busy blanks the bus
        busy = 1'b1;
        b0 = cv0;
        start_c();
        send_byte(8'hA0, 1'b1, a0, a1);
        chk("R3 no ack", int'(a0 | a1), 0);
        send_byte(8'h42, 1'b1, a0, a1);
        stop_c();
        chk("R3 no bytes", cv0 - b0, 0);
        chk("R3 no commit", cc0 + cc1, 2);
        busy = 1'b0;
        wq();

        // R9/R10: START inside a byte
        do_reset();
        start_c();
        send_byte(8'hA0, 1'b1, a0, a1);
        send_byte(8'h77, 1'b1, a0, a1);
        b0 = cv0; c1 = cv1;
        bit_out(1); bit_out(0); bit_out(1); bit_out(0);
        start_c();                      // fifth bit = 1, then START
        bit_out(0); bit_out(1); bit_out(1);
        ninth(1'b1, a0, a1);
        chk("R9 byte kept", cv0 - b0, 1);
        chk("R9 byte value", ld0, 'hAB);
        chk("R9 ack", int'(a0), 1);
        chk("R10 restarted", cv1 - c1, 0);
        bit_out(1); bit_out(1); bit_out(0); bit_out(0);
        ninth(1'b1, a0, a1);
        chk("R10 new byte", cv1 - c1, 1);
        chk("R10 value", ld1, 'h7C);
        chk("R10 addr flag", la1, 1);
        chk("R10 ack", int'(a1), 1);

        // R9/R10: STOP inside a byte
        do_reset();
        c0 = cc0; c1 = cc1; n0 = cv1;
        start_c();
        send_byte(8'hA0, 1'b1, a0, a1);
        send_byte(8'h77, 1'b1, a0, a1);
        bit_out(0); bit_out(1); bit_out(0);
        stop_c();                       // fourth bit = 0, then STOP
        chk("R10 stop commit", cc1 - c1, 1);
        chk("R9 stop ignored", cc0 - c0, 0);
        n0 = cv1;
        send_byte(8'h12, 1'b1, a0, a1);
        chk("R10 idle after stop", cv1 - n0, 0);
        chk("R10 idle ack", int'(a1), 0);

        finish_run();
    end

endmodule